// File: doc/BRIEF.md
# SPI FIFO Threshold and Interrupt Controller

This block is the data buffering and interrupt front end of an SPI controller. Software writes 32-bit words into an 8-deep transmit queue and reads received words from an 8-deep receive queue. A separate shift engine takes transmit words and delivers receive words. Software reprograms a transmit threshold and a receive threshold for each burst. The transmit threshold holds the shift engine back until a whole burst has been queued. The receive threshold marks the point at which the burst's replies have all arrived.

A receive-complete flag and a receive-overrun flag are sticky, and each has its own enable. They are combined into one level-sensitive interrupt line. A transmit-complete flag records that the last word of a released burst has left. A write to the FIFO control register can flush either queue in a single cycle.

Register map (word index on `addr_i`): 0 transmit data (write), 1 receive data (read, pops), 2 FIFO control, 3 status, 4 interrupt enable, 5 interrupt status, 6 interrupt clear.

Top module: `spi_fifo_irq`

## Requirements
- R1: After reset the status, interrupt status, interrupt enable and FIFO control registers read 0, `irq_o` is low and `tx_avail_o` is low.
- R2: Words written to register 0 leave on `tx_data_o` in write order, one per cycle in which `tx_pop_i` and `tx_avail_o` are both high. A write made while 8 words are queued is dropped.
- R3: FIFO control bits 11:8 hold the transmit threshold. `tx_avail_o` stays low until the transmit level is at or above a nonzero threshold. From then on it stays high until the queue is empty.
- R4: Words delivered with `rx_push_i` are returned by reads of register 1 in arrival order. Status bit 0 is 1 exactly while the receive queue holds data.
- R5: FIFO control bits 3:0 hold the receive threshold. Interrupt status bit 9 reads 1 while the receive level is at or above a nonzero threshold. It is never 1 when the threshold is 0.
- R6: Interrupt status bit 3 (receive complete) is set one cycle after bit 9 goes from 0 to 1. It stays set until a 1 is written to bit 3 of register 6. Writing other bits of register 6 leaves it set.
- R7: A word delivered while the receive queue holds 8 entries, with no read in the same cycle, is discarded and sets interrupt status bit 0 (overrun).
- R8: Interrupt status bit 4 (transmit complete) is set when the last queued word of a released burst is taken. Writing 1 to bit 4 of register 6 clears it.
- R9: Register 4 keeps only bit 3 (receive-complete enable) and bit 0 (overrun enable). `irq_o` is high exactly when an enabled one of status bits 3 and 0 is set.
- R10: Writing FIFO control bit 12 or bit 4 empties the transmit or receive queue, respectively, in that cycle. The thresholds written by the same access take effect, and bits 12 and 4 read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of `rd_en_i` |
| tx_pop_i | input | 1 | Shift engine takes the head transmit word |
| tx_avail_o | output | 1 | Transmit word available to the shift engine |
| tx_data_o | output | 32 | Head transmit word |
| rx_push_i | input | 1 | Shift engine delivers a receive word |
| rx_data_i | input | 32 | Received word |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong queue pointer or count shows up at the next receive read or transmit pop as an out-of-order or stale word. It can also show up as `tx_avail_o` changing on the wrong queue level. A mis-tracked threshold comparison or edge detector shows in the interrupt status one cycle after the level crosses the threshold. A sticky flag that is lost or cleared by the wrong bit shows on `irq_o` immediately. The bench therefore compares every transmitted and received word against a queue model. It also reads the status registers right after each threshold crossing, overflow and flush.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  typedef enum logic [2:0] {
    A_TXDATA = 3'd0,
    A_RXDATA = 3'd1,
    A_FCTL   = 3'd2,
    A_STAT   = 3'd3,
    A_IEN    = 3'd4,
    A_ISTAT  = 3'd5,
    A_ICLR   = 3'd6
  } reg_addr_e;

  localparam int THR_W      = 4;
  localparam int TXTHR_LSB  = 8;
  localparam int RXTHR_LSB  = 0;
  localparam int B_TX_FLUSH = 12;
  localparam int B_RX_FLUSH = 4;
  localparam int B_ROR      = 0;
  localparam int B_RXC      = 3;
  localparam int B_TXC      = 4;
  localparam int B_RXRDY    = 9;
endpackage

// File: rtl/spi_sfifo.sv
module spi_sfifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          push_acc_o,
  output logic          pop_acc_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full_o     = (cnt_q == CW'(DEPTH));
  assign empty_o    = (cnt_q == '0);
  assign pop_acc_o  = pop_i && !empty_o && !flush_i;
  assign push_acc_o = push_i && !flush_i && (!full_o || pop_acc_o);
  assign rdata_o    = mem_q[rptr_q];
  assign count_o    = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_acc_o) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_acc_o) wptr_q <= nxt(wptr_q);
      if (pop_acc_o)  rptr_q <= nxt(rptr_q);
      cnt_q <= cnt_q + CW'(push_acc_o) - CW'(pop_acc_o);
    end
  end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ie_we_i,
  input  logic ie_rxc_i,
  input  logic ie_ror_i,
  input  logic clr_rxc_i,
  input  logic clr_ror_i,
  input  logic clr_txc_i,
  input  logic rxc_ev_i,
  input  logic ror_ev_i,
  input  logic txc_ev_i,
  output logic ie_rxc_o,
  output logic ie_ror_o,
  output logic rxc_o,
  output logic ror_o,
  output logic txc_o,
  output logic irq_o
);
  logic rxc_q, ror_q, txc_q, ie_rxc_q, ie_ror_q;

  // an event in the clear cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxc_q    <= 1'b0;
      ror_q    <= 1'b0;
      txc_q    <= 1'b0;
      ie_rxc_q <= 1'b0;
      ie_ror_q <= 1'b0;
    end else begin
      rxc_q <= rxc_ev_i | (rxc_q & ~clr_rxc_i);
      ror_q <= ror_ev_i | (ror_q & ~clr_ror_i);
      txc_q <= txc_ev_i | (txc_q & ~clr_txc_i);
      if (ie_we_i) begin
        ie_rxc_q <= ie_rxc_i;
        ie_ror_q <= ie_ror_i;
      end
    end
  end

  assign ie_rxc_o = ie_rxc_q;
  assign ie_ror_o = ie_ror_q;
  assign rxc_o    = rxc_q;
  assign ror_o    = ror_q;
  assign txc_o    = txc_q;
  assign irq_o    = (rxc_q & ie_rxc_q) | (ror_q & ie_ror_q);
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tx_pop_i,
  output logic          tx_avail_o,
  output logic [DW-1:0] tx_data_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          irq_o
);
  logic tx_push, rx_pop, fctl_we, ie_we, ic_we, tx_flush, rx_flush;
  logic [THR_W-1:0] tx_thr_q, rx_thr_q;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic tx_full, tx_empty, tx_push_acc, tx_pop_acc, tx_pop;
  logic rx_full, rx_empty, rx_push_acc, rx_pop_acc;
  logic [DW-1:0] rx_head;
  logic tx_go, tx_run_q, txc_ev, rx_ready, rx_ready_q, rxc_ev, ror_ev;
  logic ie_rxc, ie_ror, st_rxc, st_ror, st_txc;
  logic [DW-1:0] istat;

  assign tx_push  = wr_en_i && (addr_i == AW'(A_TXDATA));
  assign fctl_we  = wr_en_i && (addr_i == AW'(A_FCTL));
  assign ie_we    = wr_en_i && (addr_i == AW'(A_IEN));
  assign ic_we    = wr_en_i && (addr_i == AW'(A_ICLR));
  assign rx_pop   = rd_en_i && (addr_i == AW'(A_RXDATA));
  assign tx_flush = fctl_we && wdata_i[B_TX_FLUSH];
  assign rx_flush = fctl_we && wdata_i[B_RX_FLUSH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_thr_q <= '0;
      rx_thr_q <= '0;
    end else if (fctl_we) begin
      tx_thr_q <= wdata_i[TXTHR_LSB +: THR_W];
      rx_thr_q <= wdata_i[RXTHR_LSB +: THR_W];
    end
  end

  spi_sfifo #(.DW(DW), .DEPTH(DEPTH)) tx_fifo_i (
    .clk_i, .rst_ni, .flush_i(tx_flush), .push_i(tx_push), .wdata_i(wdata_i),
    .pop_i(tx_pop), .rdata_o(tx_data_o), .count_o(tx_cnt), .full_o(tx_full),
    .empty_o(tx_empty), .push_acc_o(tx_push_acc), .pop_acc_o(tx_pop_acc)
  );

  spi_sfifo #(.DW(DW), .DEPTH(DEPTH)) rx_fifo_i (
    .clk_i, .rst_ni, .flush_i(rx_flush), .push_i(rx_push_i), .wdata_i(rx_data_i),
    .pop_i(rx_pop), .rdata_o(rx_head), .count_o(rx_cnt), .full_o(rx_full),
    .empty_o(rx_empty), .push_acc_o(rx_push_acc), .pop_acc_o(rx_pop_acc)
  );

  // transmit release: hold until a burst is queued, then run to empty
  assign tx_go      = (tx_thr_q != '0) && (32'(tx_cnt) >= 32'(tx_thr_q));
  assign tx_avail_o = !tx_empty && (tx_run_q || tx_go);
  assign tx_pop     = tx_pop_i && tx_avail_o;
  assign txc_ev     = tx_pop_acc && (tx_cnt == CW'(1)) && !tx_push_acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tx_run_q <= 1'b0;
    else if (tx_flush || txc_ev) tx_run_q <= 1'b0;
    else if (tx_go)              tx_run_q <= 1'b1;
  end

  assign rx_ready = (rx_thr_q != '0) && (32'(rx_cnt) >= 32'(rx_thr_q));
  assign rxc_ev   = rx_ready && !rx_ready_q;
  assign ror_ev   = rx_push_i && rx_full && !rx_pop_acc && !rx_flush && !rx_push_acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_ready_q <= 1'b0;
    else         rx_ready_q <= rx_ready;
  end

  spi_irq_ctrl irq_ctrl_i (
    .clk_i, .rst_ni,
    .ie_we_i(ie_we), .ie_rxc_i(wdata_i[B_RXC]), .ie_ror_i(wdata_i[B_ROR]),
    .clr_rxc_i(ic_we && wdata_i[B_RXC]), .clr_ror_i(ic_we && wdata_i[B_ROR]),
    .clr_txc_i(ic_we && wdata_i[B_TXC]),
    .rxc_ev_i(rxc_ev), .ror_ev_i(ror_ev), .txc_ev_i(txc_ev),
    .ie_rxc_o(ie_rxc), .ie_ror_o(ie_ror),
    .rxc_o(st_rxc), .ror_o(st_ror), .txc_o(st_txc), .irq_o(irq_o)
  );

  always_comb begin
    istat          = '0;
    istat[B_ROR]   = st_ror;
    istat[B_RXC]   = st_rxc;
    istat[B_TXC]   = st_txc;
    istat[B_RXRDY] = rx_ready;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr_i)
        AW'(A_RXDATA): rdata_o = rx_empty ? '0 : rx_head;
        AW'(A_FCTL): begin
          rdata_o[TXTHR_LSB +: THR_W] = tx_thr_q;
          rdata_o[RXTHR_LSB +: THR_W] = rx_thr_q;
        end
        AW'(A_STAT):  rdata_o[0] = !rx_empty;
        AW'(A_IEN): begin
          rdata_o[B_RXC] = ie_rxc;
          rdata_o[B_ROR] = ie_ror;
        end
        AW'(A_ISTAT): rdata_o = istat;
        default:      rdata_o = '0;
      endcase
    end
  end
endmodule

module spi_fifo_irq_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ic_we,
  input logic          clr_rxc_bit,
  input logic          rx_flush,
  input logic          rx_push_i,
  input logic          rx_pop_acc,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic          rx_ready,
  input logic          st_rxc,
  input logic          st_ror,
  input logic          irq_o
);
  // R2
  tx_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tx_cnt) <= DEPTH);
  // R6
  rxc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ready) |=> st_rxc);
  // R6
  rxc_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_rxc && !(ic_we && clr_rxc_bit) |=> st_rxc);
  // R7
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i && (rx_cnt == CW'(DEPTH)) && !rx_pop_acc && !rx_flush |=> st_ror);
  // R10
  rx_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush |=> (rx_cnt == '0));
  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (st_rxc || st_ror));
endmodule

bind spi_fifo_irq spi_fifo_irq_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .ic_we(ic_we), .clr_rxc_bit(wdata_i[3]),
  .rx_flush(rx_flush), .rx_push_i(rx_push_i), .rx_pop_acc(rx_pop_acc),
  .rx_cnt(rx_cnt), .tx_cnt(tx_cnt), .rx_ready(rx_ready),
  .st_rxc(st_rxc), .st_ror(st_ror), .irq_o(irq_o)
);

// File: tb/spi_fifo_irq_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_irq_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0, rd_en_i = 1'b0, tx_pop_i = 1'b0, rx_push_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rx_data_i = '0;
  logic [31:0] rdata_o, tx_data_o;
  logic tx_avail_o, irq_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] tx_exp[$];
  logic [31:0] rx_exp[$];

  always #2.5 clk_i = ~clk_i;

  spi_fifo_irq dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk_i); #1;
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
    @(posedge clk_i); #1;
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i); d = rdata_o;
    @(posedge clk_i); #1;
    rd_en_i = 1'b0;
  endtask

  task automatic tx_write(logic [31:0] d);
    reg_wr(3'd0, d);
    if (tx_exp.size() < 8) tx_exp.push_back(d);
  endtask

  task automatic rx_deliver(logic [31:0] d);
    @(posedge clk_i); #1;
    rx_push_i = 1'b1; rx_data_i = d;
    @(posedge clk_i); #1;
    rx_push_i = 1'b0;
    if (rx_exp.size() < 8) rx_exp.push_back(d);
  endtask

  task automatic rx_read(string req);
    logic [31:0] d;
    reg_rd(3'd1, d);
    if (rx_exp.size() == 0) chk(req, d, 32'h0);
    else chk(req, d, rx_exp.pop_front());
  endtask

  task automatic drain(int n);
    @(posedge clk_i); #1;
    tx_pop_i = 1'b1;
    repeat (n) @(posedge clk_i);
    #1 tx_pop_i = 1'b0;
  endtask

  // scoreboard monitor for the transmit side (R2)
  always @(negedge clk_i) begin
    if (rst_ni && tx_pop_i && tx_avail_o) begin
      if (tx_exp.size() == 0) chk("R2 unexpected word", tx_data_o, 32'hx);
      else chk("R2 tx order", tx_data_o, tx_exp.pop_front());
    end
  end

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    // R1 reset state
    reg_rd(3'd3, d); chk("R1 status", d, 0);
    reg_rd(3'd5, d); chk("R1 istat", d, 0);
    reg_rd(3'd4, d); chk("R1 ien", d, 0);
    reg_rd(3'd2, d); chk("R1 fctl", d, 0);
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 tx_avail", {31'd0, tx_avail_o}, 0);
    // R9 enable mask
    reg_wr(3'd4, 32'hFFFF_FFFF);
    reg_rd(3'd4, d); chk("R9 ien readback", d, 32'h9);
    // R3 threshold release
    reg_wr(3'd2, 32'h0000_0300);
    tx_write(32'hA0A0_0001); tx_write(32'hA0A0_0002);
    @(negedge clk_i); chk("R3 held below thr", {31'd0, tx_avail_o}, 0);
    tx_write(32'hA0A0_0003);
    @(negedge clk_i); chk("R3 released at thr", {31'd0, tx_avail_o}, 1);
    drain(3);
    @(negedge clk_i); chk("R3 idle after empty", {31'd0, tx_avail_o}, 0);
    chk("R2 all sent", tx_exp.size(), 0);
    // R8 transmit complete
    reg_rd(3'd5, d); chk("R8 txc set", d & 32'h10, 32'h10);
    reg_wr(3'd6, 32'h10);
    reg_rd(3'd5, d); chk("R8 txc cleared", d & 32'h10, 0);
    // R2 overflow drop
    reg_wr(3'd2, 32'h0000_0800);
    for (int i = 0; i < 9; i++) tx_write(32'hB000_0000 + i);
    drain(9);
    @(negedge clk_i); chk("R2 ninth dropped", {31'd0, tx_avail_o}, 0);
    chk("R2 queue drained", tx_exp.size(), 0);
    reg_wr(3'd6, 32'h10);
    // R5/R6 receive threshold
    reg_wr(3'd2, 32'h0000_0003);
    rx_deliver(32'hC000_0001); rx_deliver(32'hC000_0002);
    reg_rd(3'd3, d); chk("R4 not empty", d, 1);
    reg_rd(3'd5, d); chk("R5 below thr", d & 32'h208, 0);
    rx_deliver(32'hC000_0003);
    reg_rd(3'd5, d); chk("R5 R6 at thr", d & 32'h208, 32'h208);
    chk("R9 irq on rxc", {31'd0, irq_o}, 1);
    rx_read("R4 order"); rx_read("R4 order"); rx_read("R4 order");
    reg_rd(3'd3, d); chk("R4 empty", d, 0);
    reg_rd(3'd5, d); chk("R6 sticky after drain", d & 32'h208, 32'h8);
    reg_wr(3'd6, 32'h1);
    reg_rd(3'd5, d); chk("R6 other clear ignored", d & 32'h8, 32'h8);
    reg_wr(3'd6, 32'h8);
    reg_rd(3'd5, d); chk("R6 cleared", d & 32'h8, 0);
    chk("R9 irq low", {31'd0, irq_o}, 0);
    // R7 overrun, threshold 0
    reg_wr(3'd2, 32'h0);
    for (int i = 0; i < 9; i++) rx_deliver(32'hD000_0000 + i);
    reg_rd(3'd5, d); chk("R7 ovr set, R5 thr0", d & 32'h209, 32'h1);
    chk("R9 irq on ovr", {31'd0, irq_o}, 1);
    reg_wr(3'd4, 32'h0);
    @(negedge clk_i); chk("R9 irq masked", {31'd0, irq_o}, 0);
    for (int i = 0; i < 8; i++) rx_read("R7 kept words");
    reg_rd(3'd3, d); chk("R7 ninth discarded", d, 0);
    reg_wr(3'd6, 32'h1);
    // R10 flush
    rx_deliver(32'hE000_0001); rx_deliver(32'hE000_0002);
    reg_wr(3'd2, 32'h0000_0800);
    tx_write(32'hF000_0001); tx_write(32'hF000_0002); tx_write(32'hF000_0003);
    reg_wr(3'd2, 32'h0000_1512);
    tx_exp.delete(); rx_exp.delete();
    reg_rd(3'd2, d); chk("R10 readback", d, 32'h0000_0502);
    reg_rd(3'd3, d); chk("R10 rx flushed", d, 0);
    tx_write(32'hF100_0001); tx_write(32'hF100_0002);
    @(negedge clk_i); chk("R10 tx flushed", {31'd0, tx_avail_o}, 0);
    tx_write(32'hF100_0003); tx_write(32'hF100_0004); tx_write(32'hF100_0005);
    @(negedge clk_i); chk("R10 R3 new thr", {31'd0, tx_avail_o}, 1);
    drain(5);
    chk("R10 R2 post-flush words", tx_exp.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule